// File: doc/BRIEF.md
# Time-Shared Two-Stage Sigma-Delta Noise Canceller

This block merges the single-bit decisions of two cascaded first-order sigma-delta stages into one signed multi-level word per sample. The two stages share their integrators in time. For that reason each sample period spans two beats of the input clock. Stage 1 decides in the first beat, which is phase 1. Stage 2 decides in the second beat, which is phase 2, and it has by then seen the stage-1 error of the same sample. An internal divide-by-2 phase generator tells the two beats apart.

A one-beat (half-sample) register holds the stage-1 decision until the stage-2 decision arrives. A sample-wide (full-sample) register keeps the previous stage-2 decision. From these the block forms the stage-1 value minus the first difference of the stage-2 value. The stage-1 quantisation error then drops out. The only error left in the output is the stage-2 error, shaped by a second-order difference.

The input side carries `in_valid` and has no ready: the block accepts every valid beat and never applies back-pressure. When `in_valid` is low the beat does not exist, and all state holds. The output side has no ready either. `res_valid` is a one-clock pulse that the consumer must take, and `res_data` keeps its value until the next pulse.

Top module: `mash_cancel`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `res_valid` is 0 and `res_data` is 0. The next valid beat is treated as phase 1.
- R2: Valid beats alternate between phase 1 and phase 2. `res_valid` is 1 during exactly the clock that follows each phase-2 beat and is 0 at every other time.
- R3: `s1_bit` is captured only on phase-1 beats. Its value on a phase-2 beat has no effect on the output.
- R4: `s2_bit` is used only on phase-2 beats. Its value on a phase-1 beat has no effect on the output.
- R5: A clock with `in_valid` low leaves the phase, both delay registers and `res_data` unchanged, and it produces no `res_valid` pulse.
- R6: A bit value of 1 stands for +1 and a bit value of 0 stands for -1. For sample n, `res_data` = L(s1[n]) - L(s2[n]) + L(s2[n-1]), written as 3-bit two's complement. Because it is a sum of three odd terms, the result is always odd.
- R7: After reset the previous stage-2 value s2[n-1] is taken as -1 (bit 0).
- R8: `res_data` stays within -3..+3. The code 3'b100 never appears. Both extremes, +3 (3'b011) and -3 (3'b101), can be reached.
- R9: With the two stages modelled as integrators whose inter-stage gain is 1, res[n] equals x[n-1] minus the second difference of the stage-2 error: x[n-1] - e2[n] + 2e2[n-1] - e2[n-2].
- R10: Between pulses `res_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, two beats per sample |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The current clock is a beat |
| s1_bit | input | 1 | Stage-1 decision, read on phase 1 |
| s2_bit | input | 1 | Stage-2 decision, read on phase 2 |
| res_valid | output | 1 | One-clock pulse per sample |
| res_data | output | 3 | Signed combined sample |

## Verification
A phase counter that slips shows at the ports within one beat. `res_valid` then rises after the wrong beat, and the bit captured from the other input corrupts the value. A delay register that holds the wrong level shifts `res_data` by exactly 2 on the very next pulse, so it is visible one sample later. The integrator model checks the cancellation identity on every sample. That exposes any error in the order of alignment or in the sign, even one that keeps every result inside the -3..+3 range.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int unsigned RES_W = 3;

  typedef enum logic {PH_ONE = 1'b0, PH_TWO = 1'b1} phase_e;

  // bit 1 -> +1, bit 0 -> -1
  function automatic logic signed [RES_W-1:0] lvl(input logic b);
    return b ? RES_W'(1) : -RES_W'(1);
  endfunction
endpackage

// File: rtl/mash_phase_gen.sv
module mash_phase_gen
  import mash_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   beat,
  output phase_e phase,
  output logic   beat_one,
  output logic   beat_two
);
  phase_e ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ph_q <= PH_ONE;
    else if (beat) ph_q <= (ph_q == PH_ONE) ? PH_TWO : PH_ONE;
  end

  assign phase    = ph_q;
  assign beat_one = beat && (ph_q == PH_ONE);
  assign beat_two = beat && (ph_q == PH_TWO);
endmodule

// File: rtl/mash_bit_delay.sv
module mash_bit_delay #(
  parameter int unsigned DEPTH   = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] chain;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n)   chain[0] <= RST_VAL;
          else if (en)  chain[0] <= d;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (!rst_n)   chain[i] <= RST_VAL;
          else if (en)  chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/mash_combine.sv
module mash_combine
  import mash_pkg::*;
#(
  parameter int unsigned W = RES_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic                y1_aligned,
  input  logic                y2_now,
  input  logic                y2_prev,
  output logic                res_valid,
  output logic signed [W-1:0] res_data
);
  logic signed [W-1:0] sum;

  always_comb begin
    sum = W'(lvl(y1_aligned)) - W'(lvl(y2_now)) + W'(lvl(y2_prev));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= fire;
      if (fire) res_data <= sum;
    end
  end
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel
  import mash_pkg::*;
#(
  parameter int unsigned HALF_DEPTH = 1,
  parameter int unsigned FULL_DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             s1_bit,
  input  logic             s2_bit,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data
);
  phase_e phase;
  logic   beat_one, beat_two;
  logic   y1_half, y2_full;
  logic signed [RES_W-1:0] res_s;

  mash_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .beat(in_valid),
    .phase(phase), .beat_one(beat_one), .beat_two(beat_two)
  );

  // half-sample: held from the phase-1 beat to the phase-2 beat
  mash_bit_delay #(.DEPTH(HALF_DEPTH), .RST_VAL(1'b0)) u_half (
    .clk(clk), .rst_n(rst_n), .en(beat_one), .d(s1_bit), .q(y1_half)
  );

  // full-sample: advanced once per sample, on phase 2
  mash_bit_delay #(.DEPTH(FULL_DEPTH), .RST_VAL(1'b0)) u_full (
    .clk(clk), .rst_n(rst_n), .en(beat_two), .d(s2_bit), .q(y2_full)
  );

  mash_combine #(.W(RES_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .fire(beat_two),
    .y1_aligned(y1_half), .y2_now(s2_bit), .y2_prev(y2_full),
    .res_valid(res_valid), .res_data(res_s)
  );

  assign res_data = res_s;
endmodule

// File: rtl/mash_cancel_chk.sv
module mash_cancel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       res_valid,
  input logic [2:0] res_data
);
  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_data));

  // R8
  no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_data != 3'b100);

  // R6
  odd_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_data[0]);
endmodule

bind mash_cancel mash_cancel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .res_valid(res_valid), .res_data(res_data)
);

// File: tb/mash_cancel_bench.sv
module mash_cancel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       s1_bit = 1'b0;
  logic       s2_bit = 1'b0;
  logic       res_valid;
  logic [2:0] res_data;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 0;
  bit  y2p = 0;   // previous stage-2 bit as the requirements define it

  always #5 clk = ~clk;

  mash_cancel u_mash_cancel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .s1_bit(s1_bit), .s2_bit(s2_bit),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic int lv(input bit b);
    return b ? 1 : -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs set at a negedge, result observed at the next negedge
  task automatic step(input bit v, input bit a, input bit b);
    in_valid = v; s1_bit = a; s2_bit = b;
    @(negedge clk);
  endtask

  // one sample; ja / jb are the values on the beat where the pin is ignored
  task automatic sample(input bit a, input bit b, input bit ja, input bit jb,
                        input string req, output int got);
    step(1, a, jb);
    chk({req, " R2 no pulse after phase 1"}, int'(res_valid), 0);
    step(1, ja, b);
    chk({req, " R2 pulse after phase 2"}, int'(res_valid), 1);
    got = int'($signed(res_data));
    chk({req, " R6 value"}, got, lv(a) - lv(b) + lv(y2p));
    y2p = b;
  endtask

  task automatic do_reset();
    in_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", int'(res_valid), 0);
    chk("R1 data in reset", int'(res_data), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", int'(res_valid), 0);
    chk("R1 data after reset", int'(res_data), 0);
    y2p = 0;
  endtask

  task automatic t_first_sample();
    int g;
    do_reset();
    sample(1, 0, 1, 0, "R7 prev=-1", g);
    chk("R7 first sample", g, 1);
  endtask

  task automatic t_extremes();
    int g;
    do_reset();
    sample(1, 1, 0, 0, "R8 prime", g);
    sample(1, 0, 0, 0, "R8 top", g);
    chk("R8 +3 code", int'(res_data), 3);
    sample(0, 1, 1, 1, "R8 prime2", g);
    sample(0, 1, 1, 1, "R8 mid", g);
    chk("R8 mid -1", g, -1);
    sample(0, 0, 1, 1, "R8 prime3", g);
    sample(0, 1, 1, 0, "R8 bottom", g);
    chk("R8 -3 code", int'(res_data), 5);
  endtask

  task automatic t_ignore();
    int g1, g2;
    do_reset();
    sample(1, 1, 0, 0, "R3 base", g1);
    do_reset();
    sample(1, 1, 1, 1, "R3 junk", g2);
    chk("R3 s1 on phase 2 ignored", g2, g1);
    do_reset();
    sample(0, 0, 1, 1, "R4 base", g1);
    sample(1, 1, 1, 0, "R4 base2", g1);
    do_reset();
    sample(0, 0, 0, 0, "R4 junk", g2);
    sample(1, 1, 0, 1, "R4 junk2", g2);
    chk("R4 s2 on phase 1 ignored", g2, g1);
  endtask

  task automatic t_stall();
    int g, held;
    do_reset();
    sample(1, 0, 1, 1, "R5 pre", g);
    held = int'(res_data);
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 1);
      chk("R5 no pulse while idle", int'(res_valid), 0);
      chk("R10 data held", int'(res_data), held);
    end
    step(1, 0, 1);
    chk("R5 phase 1 resumes", int'(res_valid), 0);
    step(0, 1, 0);
    chk("R5 idle mid-sample", int'(res_valid), 0);
    step(1, 1, 0);
    chk("R5 phase 2 after stall", int'(res_valid), 1);
    chk("R5 value after stall", int'($signed(res_data)), lv(0) - lv(0) + lv(y2p));
    y2p = 0;
  endtask

  task automatic t_cadence();
    int pulses = 0;
    do_reset();
    for (int i = 0; i < 10; i++) begin
      step(1, i[0], i[1]);
      if (res_valid) pulses++;
      chk("R2 cadence", int'(res_valid), i % 2);
    end
    chk("R2 pulse count", pulses, 5);
  endtask

  task automatic t_noise();
    real v1 = -0.5, v2 = -0.5, x, xprev = 0.0, e1, e2;
    real e2h [0:2];
    bit  y1b, y1prevb = 0, y2b, y2prevb = 0;
    int  g;
    do_reset();
    e2h[0] = 0.0; e2h[1] = 0.0; e2h[2] = 0.0;
    for (int n = 0; n < 300; n++) begin
      x = 0.7 * (real'(n % 37) / 18.0 - 1.0);
      v1 = v1 + xprev - real'(lv(y1prevb));
      y1b = (v1 >= 0.0);
      e1 = real'(lv(y1b)) - v1;
      v2 = v2 + e1 - real'(lv(y2prevb));
      y2b = (v2 >= 0.0);
      e2 = real'(lv(y2b)) - v2;
      e2h[2] = e2h[1]; e2h[1] = e2h[0]; e2h[0] = e2;
      sample(y1b, y2b, ~y1b, ~y2b, "R9 stream", g);
      if (n >= 2) begin
        real want = xprev - e2h[0] + 2.0 * e2h[1] - e2h[2];
        n_chk++;
        if ((real'(g) - want) > 1e-6 || (want - real'(g)) > 1e-6) begin
          n_err++;
          $display("FAIL R9 cancel n=%0d actual=%0d expected=%f", n, g, want);
        end
      end
      xprev = x; y1prevb = y1b; y2prevb = y2b;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_first_sample();
    t_extremes();
    t_ignore();
    t_stall();
    t_cadence();
    t_noise();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule